// File: doc/BRIEF.md
# Delay-Add Butterfly Dedispersion Engine

This block is the processing element of a tree-style incoherent dedispersion engine. It has the shape of a radix-2 FFT butterfly, but the twiddle multiply is replaced by a delay of a programmable number of samples. Each pass takes one pair of subband streams, A and B. For every sample index it produces two results: the straight sum of A and B, and the sum of A with a delayed copy of B.

A pass begins with a start pulse. The delay for the pass is captured at that moment, and the delay history is cleared. Input pairs enter a small input buffer and are pushed through the butterfly. Results collect in an output buffer until downstream takes them. A done pulse marks the departure of the last result.

A pass controller also keeps track of the tree. A tree over N subbands has log2(N) stages, and each stage has N/2 pair passes. After the final pass of the final stage, the controller flags tree completion.

Both streaming edges use valid/ready. A transfer happens on a clock edge where valid and ready are both high. `in_ready` does not depend on `in_valid`. Once `out_valid` is high, it and both result words stay unchanged until `out_ready` takes them. A full output buffer stops the butterfly, which in turn stops the input side. No sample is dropped or reordered.

Top module: `dd_butterfly_engine`

## Requirements
- R1: `out_sum` for the k-th result of a pass equals A[k] + B[k], taken modulo 2^ACC_W, where ACC_W = IN_W + log2(N).
- R2: `out_dly` for the k-th result equals A[k] + B[k-d] modulo 2^ACC_W. B[k-d] counts as zero when k < d. With d = 0, `out_dly` equals `out_sum`.
- R3: The 4-bit `cfg_delay` is sampled only on a `start` accepted while idle, so d ranges from 0 to 15. A `start` pulse or a `cfg_delay` change during a busy pass has no effect on that pass's results.
- R4: The delay history is cleared at each accepted start, so no B samples from an earlier pass appear in `out_dly`.
- R5: A pass accepts exactly BLK_LEN input pairs. `in_ready` is low while idle, and it stays low once BLK_LEN pairs have been taken.
- R6: `done` is high for exactly one cycle. It rises in the cycle after the handshake of the last result, and a new start is accepted from that cycle onward.
- R7: Under back-pressure, `out_valid`, `out_sum` and `out_dly` hold steady until they are taken. Results leave in input order and none are lost.
- R8: `pair_idx` counts 0 to N/2-1 and advances after every pass. When it wraps, `stage_idx` advances through 0 to log2(N)-1. `tree_done` pulses together with `done` on the last pass of the last stage, and both indices then return to 0.
- R9: After reset, `in_ready`, `out_valid`, `done` and `tree_done` are 0, and `stage_idx` and `pair_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a pass when idle |
| cfg_delay | input | 4 | Delay d for the next pass |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted this cycle if valid |
| in_a | input | ACC_W | Subband A sample |
| in_b | input | ACC_W | Subband B sample |
| out_valid | output | 1 | Result pair valid |
| out_ready | input | 1 | Downstream takes result |
| out_sum | output | ACC_W | A + B |
| out_dly | output | ACC_W | A + delayed B |
| done | output | 1 | Pass complete pulse |
| tree_done | output | 1 | Final pass of final stage complete |
| stage_idx | output | STG_W | Current tree stage |
| pair_idx | output | PAIR_W | Current pair within stage |

## Verification
Some properties are checked by assertions on every cycle:
- Neither buffer is pushed when full or popped when empty.
- Held results stay stable under back-pressure.
- The captured delay does not move during a pass.
- `done` never lasts two cycles.
- The accepted count and the stage index stay inside their bounds.

The arithmetic can only be shown by bench scenarios that compare every result against sums computed from the stimulus. These cover the zero-filled start of the delayed path, the clearing between passes, delays of 0 and of 15 (15 exceeds the block length), the ignored mid-pass start, and the stage/pair walk up to `tree_done`.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int CFG_DLY_W = 4;
  localparam int MAX_DLY   = (1 << CFG_DLY_W) - 1;
endpackage

// File: rtl/dd_fifo.sv
module dd_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) begin
        mem[wp[AW-1:0]] <= wdata;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
    end
  end

  assert_fifo_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  assert_fifo_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/dd_delay_line.sv
module dd_delay_line #(
  parameter int W     = 11,
  parameter int DLY_W = dd_pkg::CFG_DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic [DLY_W-1:0] dly,
  input  logic [W-1:0]     b_now,
  output logic [W-1:0]     b_tap
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [W-1:0] hist [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) hist[0] <= '0;
    else if (shift)    hist[0] <= b_now;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n || clr) hist[g] <= '0;
      else if (shift)    hist[g] <= hist[g-1];
    end
  end

  always_comb begin
    if (dly == '0) b_tap = b_now;
    else           b_tap = hist[dly - 1'b1];
  end
endmodule

// File: rtl/dd_pass_ctrl.sv
module dd_pass_ctrl #(
  parameter int BLK_LEN = 8,
  parameter int LOG2N   = 3,
  parameter int DLY_W   = dd_pkg::CFG_DLY_W,
  parameter int STG_W   = 2,
  parameter int PAIR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DLY_W-1:0]  cfg_dly,
  input  logic              in_fire,
  input  logic              proc_fire,
  input  logic              out_fire,
  output logic              busy,
  output logic              clr,
  output logic [DLY_W-1:0]  dly_q,
  output logic              in_room,
  output logic              proc_room,
  output logic              done,
  output logic              tree_done,
  output logic [STG_W-1:0]  stage_idx,
  output logic [PAIR_W-1:0] pair_idx
);
  localparam int CNT_W     = $clog2(BLK_LEN + 1);
  localparam int PAIRS     = (1 << LOG2N) / 2;
  localparam logic [CNT_W-1:0]  LEN_C   = CNT_W'(BLK_LEN);
  localparam logic [CNT_W-1:0]  LAST_C  = CNT_W'(BLK_LEN - 1);
  localparam logic [PAIR_W-1:0] PAIR_LAST = PAIR_W'(PAIRS - 1);
  localparam logic [STG_W-1:0]  STG_LAST  = STG_W'(LOG2N - 1);

  logic [CNT_W-1:0] in_cnt, proc_cnt, out_cnt;
  logic last_out;

  assign clr       = start && !busy;
  assign in_room   = busy && (in_cnt < LEN_C);
  assign proc_room = busy && (proc_cnt < LEN_C);
  assign last_out  = out_fire && (out_cnt == LAST_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; dly_q <= '0; done <= 1'b0; tree_done <= 1'b0;
      in_cnt <= '0; proc_cnt <= '0; out_cnt <= '0;
      stage_idx <= '0; pair_idx <= '0;
    end else begin
      done      <= 1'b0;
      tree_done <= 1'b0;
      if (clr) begin
        busy <= 1'b1; dly_q <= cfg_dly;
        in_cnt <= '0; proc_cnt <= '0; out_cnt <= '0;
      end else if (busy) begin
        if (in_fire)   in_cnt   <= in_cnt + 1'b1;
        if (proc_fire) proc_cnt <= proc_cnt + 1'b1;
        if (out_fire)  out_cnt  <= out_cnt + 1'b1;
        if (last_out) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (pair_idx == PAIR_LAST) begin
            pair_idx <= '0;
            if (stage_idx == STG_LAST) begin
              stage_idx <= '0;
              tree_done <= 1'b1;
            end else begin
              stage_idx <= stage_idx + 1'b1;
            end
          end else begin
            pair_idx <= pair_idx + 1'b1;
          end
        end
      end
    end
  end

  assert_delay_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(dly_q)));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= LEN_C);
  assert_stage_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stage_idx <= STG_LAST);
endmodule

// File: rtl/dd_butterfly_engine.sv
module dd_butterfly_engine #(
  parameter int IN_W    = 8,
  parameter int LOG2N   = 3,
  parameter int BLK_LEN = 8,
  parameter int BUF_D   = 4,
  parameter int ACC_W   = IN_W + LOG2N,
  parameter int STG_W   = (LOG2N > 1) ? $clog2(LOG2N) : 1,
  parameter int PAIR_W  = (LOG2N > 1) ? (LOG2N - 1) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [dd_pkg::CFG_DLY_W-1:0] cfg_delay,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ACC_W-1:0]            in_a,
  input  logic [ACC_W-1:0]            in_b,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [ACC_W-1:0]            out_sum,
  output logic [ACC_W-1:0]            out_dly,
  output logic                        done,
  output logic                        tree_done,
  output logic [STG_W-1:0]            stage_idx,
  output logic [PAIR_W-1:0]           pair_idx
);
  localparam int DLY_W = dd_pkg::CFG_DLY_W;
  localparam int PW    = 2 * ACC_W;

  logic             busy, clr, in_room, proc_room;
  logic [DLY_W-1:0] dly_q;
  logic             in_fire, proc_fire, out_fire;
  logic [PW-1:0]    ib_rdata, ob_wdata, ob_rdata;
  logic             ib_full, ib_empty, ob_full, ob_empty;
  logic [ACC_W-1:0] a_cur, b_cur, b_tap;

  assign in_ready  = in_room && !ib_full;
  assign in_fire   = in_valid && in_ready;
  assign proc_fire = proc_room && !ib_empty && !ob_full;
  assign out_valid = !ob_empty;
  assign out_fire  = out_valid && out_ready;

  dd_pass_ctrl #(.BLK_LEN(BLK_LEN), .LOG2N(LOG2N), .DLY_W(DLY_W),
                 .STG_W(STG_W), .PAIR_W(PAIR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dly(cfg_delay),
    .in_fire(in_fire), .proc_fire(proc_fire), .out_fire(out_fire),
    .busy(busy), .clr(clr), .dly_q(dly_q), .in_room(in_room),
    .proc_room(proc_room), .done(done), .tree_done(tree_done),
    .stage_idx(stage_idx), .pair_idx(pair_idx));

  dd_fifo #(.W(PW), .DEPTH(BUF_D)) u_in_buf (
    .clk(clk), .rst_n(rst_n), .push(in_fire), .wdata({in_a, in_b}),
    .pop(proc_fire), .rdata(ib_rdata), .full(ib_full), .empty(ib_empty));

  assign a_cur = ib_rdata[PW-1:ACC_W];
  assign b_cur = ib_rdata[ACC_W-1:0];

  dd_delay_line #(.W(ACC_W), .DLY_W(DLY_W)) u_dline (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift(proc_fire),
    .dly(dly_q), .b_now(b_cur), .b_tap(b_tap));

  assign ob_wdata = {a_cur + b_cur, a_cur + b_tap};

  dd_fifo #(.W(PW), .DEPTH(BUF_D)) u_out_buf (
    .clk(clk), .rst_n(rst_n), .push(proc_fire), .wdata(ob_wdata),
    .pop(out_fire), .rdata(ob_rdata), .full(ob_full), .empty(ob_empty));

  assign out_sum = ob_rdata[PW-1:ACC_W];
  assign out_dly = ob_rdata[ACC_W-1:0];

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_dly)));
  assert_idle_no_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
endmodule

// File: tb/dd_butterfly_engine_bench.sv
module dd_butterfly_engine_bench;
  localparam int IN_W = 8, LOG2N = 3, L = 8, ACC_W = IN_W + LOG2N;
  localparam int STG_W = 2, PAIR_W = 2;
  localparam int MSK = (1 << ACC_W) - 1;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, out_ready = 0;
  logic [3:0] cfg_delay = 0;
  logic [ACC_W-1:0] in_a = 0, in_b = 0, out_sum, out_dly;
  logic in_ready, out_valid, done, tree_done;
  logic [STG_W-1:0] stage_idx;
  logic [PAIR_W-1:0] pair_idx;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dd_butterfly_engine #(.IN_W(IN_W), .LOG2N(LOG2N), .BLK_LEN(L)) u_dd_butterfly_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_delay(cfg_delay),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum), .out_dly(out_dly),
    .done(done), .tree_done(tree_done), .stage_idx(stage_idx), .pair_idx(pair_idx));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int va(input int s, input int i); return (s*37 + i*53 + 5) & MSK; endfunction
  function automatic int vb(input int s, input int i); return (s*91 + i*29 + 700) & MSK; endfunction

  task automatic run_pass(input int d, input int s, input int mode, input bit busy_start, input int p);
    int ai = 0, oi = 0, cyc = 0;
    bit hold = 0;
    int hs = 0, hd = 0;
    chk("R8 pair_idx", pair_idx, p % 4);
    chk("R8 stage_idx", stage_idx, (p / 4) % 3);
    @(negedge clk); start = 1; cfg_delay = 4'(d);
    @(negedge clk); start = 0; cfg_delay = 4'(~d);
    while (oi < L && cyc < 400) begin
      @(negedge clk); cyc++;
      in_valid  = (ai < L) && (mode == 0 || ((cyc + s) % 3) != 0);
      in_a      = ACC_W'(va(s, ai));
      in_b      = ACC_W'(vb(s, ai));
      out_ready = (mode == 0) || ((cyc % 4) == 1) || (mode == 1 && cyc > 20);
      start     = busy_start && (cyc == 3);
      #1;
      if (hold) begin
        chk("R7 valid held", out_valid, 1);
        chk("R7 sum held", out_sum, hs);
        chk("R7 dly held", out_dly, hd);
      end
      hold = out_valid && !out_ready; hs = out_sum; hd = out_dly;
      if (in_valid && in_ready) ai++;
      if (out_valid && out_ready) begin
        chk("R1 sum", out_sum, (va(s, oi) + vb(s, oi)) & MSK);
        chk((oi < d) ? "R4 dly zero history" : (busy_start ? "R3 dly kept" : "R2 dly"),
            out_dly, (va(s, oi) + ((oi >= d) ? vb(s, oi - d) : 0)) & MSK);
        oi++;
      end
    end
    start = 0; in_valid = 1;
    @(negedge clk); #1;
    chk("R5 accepted count", ai, L);
    chk("R6 done pulse", done, 1);
    chk("R8 tree_done", tree_done, (p % 12 == 11) ? 1 : 0);
    chk("R5 in_ready idle", in_ready, 0);
    @(negedge clk); #1;
    chk("R6 done single", done, 0);
    chk("R7 nothing extra", out_valid, 0);
    in_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ds[12] = '{1, 0, 2, 3, 5, 7, 8, 15, 1, 4, 6, 15};
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R9 in_ready", in_ready, 0);
    chk("R9 out_valid", out_valid, 0);
    chk("R9 done", done, 0);
    chk("R9 tree_done", tree_done, 0);
    chk("R9 stage", stage_idx, 0);
    chk("R9 pair", pair_idx, 0);
    for (int p = 0; p < 12; p++)
      run_pass(ds[p], p + 3, p % 3, (p == 4 || p == 9), p);
    chk("R8 wrap stage", stage_idx, 0);
    chk("R8 wrap pair", pair_idx, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule